// File: doc/BRIEF.md
# Digital Delta Modulation Codec

This block turns a stream of signed samples into a one-bit delta-coded stream and decodes that stream back into a staircase approximation of the input. On each sample tick the encoder compares the current input sample with a tracking accumulator. It sends out one bit that says whether the input sits above the tracked value, and it moves the accumulator one step toward the input. A decoder accumulator built the same way consumes the bits and produces the reconstructed value. The two accumulators move in lockstep, one clock apart.

The sample tick comes from a divider on the fast system clock. A 2-bit rate selector sets the tick rate, and each code above zero doubles the rate of the one before it. With the default divider and a 200 MHz clock, the lowest code gives a tick near 32 kHz. A separate 2-bit gain selector sets the step size, and each code doubles it. The step that goes with each bit travels alongside that bit, so the decoder always applies the same step the encoder used. A run detector watches the emitted bits and raises a flag when they stop alternating. This pattern shows that the staircase cannot keep up with the input.

Top module: `delta_codec`

## Requirements
- R1: At each tick the emitted bit is 1 when the signed sample present at that tick is strictly greater than the encoder's tracked value, and 0 otherwise (equal gives 0).
- R2: At each tick the tracked value rises by one step after a 1 decision and falls by one step after a 0 decision.
- R3: Ticks are spaced BASE_DIV >> rate_sel clock cycles apart: codes 0,1,2,3 give BASE_DIV, BASE_DIV/2, BASE_DIV/4 and BASE_DIV/8 cycles.
- R4: The step size is STEP_BASE << gain_sel, so each increment of the gain code doubles the step.
- R5: The 16-bit signed accumulators clamp at 32767 and -32768 and never wrap.
- R6: A synchronous reset clears both accumulators, the bit, the strobe and the overload flag to 0. The first strobe follows the first tick after reset.
- R7: bit_valid is high for exactly one cycle per tick, in the cycle after that tick, and dm_bit holds the decision in that cycle.
- R8: recon_out changes in the cycle after each strobe. It then equals the encoder's tracked value after the same update, using the step that the bit was coded with.
- R9: overload is updated on each strobe. It is 1 when the last 8 received bits are all equal, and 0 when fewer than 8 bits have arrived since reset or when those bits differ.
- R10: With a constant zero input after reset, the bits strictly alternate, starting with 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | 2 | Tick rate code, doubling per increment |
| gain_sel | input | 2 | Step gain code, doubling per increment |
| sample_in | input | 16 | Signed input sample |
| dm_bit | output | 1 | Coded bit, 1 = step up |
| bit_valid | output | 1 | One-cycle strobe qualifying dm_bit |
| recon_out | output | 16 | Signed reconstructed staircase value |
| overload | output | 1 | Last 8 bits all equal |

## Verification
The assertions assume that BASE_DIV is at least 16 and divisible by 8, so that ticks can never fall in back-to-back cycles. They also assume that the step times the largest gain fits well inside the accumulator range. Samples, rate codes and gain codes may change on any cycle. The bench drives them only on the falling edge and keeps the default divider ratios, while it sweeps every rate and gain code, full-scale inputs and fast ramps. Under these conditions both accumulators start equal at reset and stay equal.

// File: rtl/dm_pkg.sv
package dm_pkg;
  localparam int ACC_W = 16;
  typedef logic signed [ACC_W-1:0] acc_t;

  // One saturating step of a tracking accumulator.
  function automatic acc_t sat_move(acc_t a, logic up, logic [ACC_W-1:0] st);
    logic signed [ACC_W+1:0] w;
    logic signed [ACC_W+1:0] hi;
    logic signed [ACC_W+1:0] lo;
    hi = {3'b000, {(ACC_W-1){1'b1}}};
    lo = {3'b111, {(ACC_W-1){1'b0}}};
    if (up) w = $signed({a[ACC_W-1], a[ACC_W-1], a}) + $signed({2'b00, st});
    else    w = $signed({a[ACC_W-1], a[ACC_W-1], a}) - $signed({2'b00, st});
    if (w > hi)      return hi[ACC_W-1:0];
    else if (w < lo) return lo[ACC_W-1:0];
    else             return w[ACC_W-1:0];
  endfunction
endpackage

// File: rtl/dm_tick_gen.sv
module dm_tick_gen #(
  parameter int BASE_DIV = 6256,
  localparam int DIV_W = $clog2(BASE_DIV + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] rate_sel,
  output logic       tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] div;
  logic             hit;

  assign div = DIV_W'(BASE_DIV) >> rate_sel;
  // >= lets a shortened period after a rate change fire at once
  assign hit = (cnt >= div - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= hit;
      cnt  <= hit ? '0 : cnt + DIV_W'(1);
    end
  end

  // R3: ticks are never adjacent for any rate code
  a_r3_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/dm_acc.sv
module dm_acc (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        en,
  input  logic                        up,
  input  logic [dm_pkg::ACC_W-1:0]    step,
  output dm_pkg::acc_t                acc
);
  always_ff @(posedge clk) begin
    if (rst)     acc <= '0;
    else if (en) acc <= dm_pkg::sat_move(acc, up, step);
  end

  // R2: direction of movement follows the decision
  a_r2_rise_on_up: assert property (@(posedge clk) disable iff (rst)
    (en && up) |=> (acc >= $past(acc)));
  a_r2_fall_on_down: assert property (@(posedge clk) disable iff (rst)
    (en && !up) |=> (acc <= $past(acc)));
  // R5: no wrap across the sign boundary
  a_r5_no_wrap_up: assert property (@(posedge clk) disable iff (rst)
    (en && up && acc >= 0) |=> (acc >= 0));
  a_r5_no_wrap_down: assert property (@(posedge clk) disable iff (rst)
    (en && !up && acc < 0) |=> (acc < 0));
endmodule

// File: rtl/dm_encoder.sv
module dm_encoder (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     tick,
  input  dm_pkg::acc_t             sample,
  input  logic [dm_pkg::ACC_W-1:0] step,
  output logic                     bit_q,
  output logic                     valid_q,
  output logic [dm_pkg::ACC_W-1:0] step_q,
  output dm_pkg::acc_t             track
);
  logic above;
  assign above = (sample > track);

  dm_acc u_track (
    .clk (clk),
    .rst (rst),
    .en  (tick),
    .up  (above),
    .step(step),
    .acc (track)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q   <= 1'b0;
      valid_q <= 1'b0;
      step_q  <= '0;
    end else begin
      valid_q <= tick;
      if (tick) begin
        bit_q  <= above;
        step_q <= step;
      end
    end
  end

  // R7: strobe appears exactly in the cycle after a tick
  a_r7_strobe_after_tick: assert property (@(posedge clk) disable iff (rst)
    tick |=> valid_q);
  a_r7_no_spurious_strobe: assert property (@(posedge clk) disable iff (rst)
    !tick |=> !valid_q);
endmodule

// File: rtl/dm_run_detect.sv
module dm_run_detect #(
  parameter int RUN_LEN = 8,
  localparam int FILL_W = $clog2(RUN_LEN + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic valid,
  input  logic bit_in,
  output logic flag
);
  logic [RUN_LEN-1:0] hist;
  logic [FILL_W-1:0]  fill;
  logic [RUN_LEN-1:0] hist_n;
  logic               full_n;

  assign hist_n = {hist[RUN_LEN-2:0], bit_in};
  assign full_n = (fill >= FILL_W'(RUN_LEN - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= '0;
      fill <= '0;
      flag <= 1'b0;
    end else if (valid) begin
      hist <= hist_n;
      if (fill != FILL_W'(RUN_LEN)) fill <= fill + FILL_W'(1);
      flag <= full_n && ((&hist_n) || !(|hist_n));
    end
  end

  // R9: the flag needs a full window of history
  a_r9_needs_full_window: assert property (@(posedge clk) disable iff (rst)
    flag |-> (fill == FILL_W'(RUN_LEN)));
endmodule

// File: rtl/delta_codec.sv
module delta_codec #(
  parameter int BASE_DIV  = 6256,
  parameter int STEP_BASE = 64,
  parameter int RUN_LEN   = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [1:0]               rate_sel,
  input  logic [1:0]               gain_sel,
  input  logic signed [15:0]       sample_in,
  output logic                     dm_bit,
  output logic                     bit_valid,
  output logic signed [15:0]       recon_out,
  output logic                     overload
);
  localparam int AW = dm_pkg::ACC_W;

  logic          tick;
  logic [AW-1:0] step;
  logic [AW-1:0] step_q;
  dm_pkg::acc_t  enc_track;
  dm_pkg::acc_t  dec_track;

  assign step = AW'(STEP_BASE) << gain_sel;

  dm_tick_gen #(.BASE_DIV(BASE_DIV)) u_tick (
    .clk     (clk),
    .rst     (rst),
    .rate_sel(rate_sel),
    .tick    (tick)
  );

  dm_encoder u_enc (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .sample (sample_in),
    .step   (step),
    .bit_q  (dm_bit),
    .valid_q(bit_valid),
    .step_q (step_q),
    .track  (enc_track)
  );

  // decoder: identical accumulator driven by the coded stream
  dm_acc u_dec (
    .clk (clk),
    .rst (rst),
    .en  (bit_valid),
    .up  (dm_bit),
    .step(step_q),
    .acc (dec_track)
  );

  dm_run_detect #(.RUN_LEN(RUN_LEN)) u_run (
    .clk   (clk),
    .rst   (rst),
    .valid (bit_valid),
    .bit_in(dm_bit),
    .flag  (overload)
  );

  assign recon_out = dec_track;

  // R8: decoder lands on the encoder's value one cycle after each strobe
  a_r8_lockstep: assert property (@(posedge clk) disable iff (rst)
    bit_valid |=> (recon_out == $past(enc_track)));
endmodule

// File: tb/sim_delta_codec.sv
module sim_delta_codec;
  localparam int BDIV = 16;
  localparam int SBASE = 64;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [1:0]        rate_sel = 2'd0;
  logic [1:0]        gain_sel = 2'd0;
  logic signed [15:0] sample_in = '0;
  logic              dm_bit;
  logic              bit_valid;
  logic signed [15:0] recon_out;
  logic              overload;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit cmp_on = 1'b0;

  always #2.5 clk = ~clk;

  delta_codec #(.BASE_DIV(BDIV), .STEP_BASE(SBASE), .RUN_LEN(8)) u0 (
    .clk(clk), .rst(rst), .rate_sel(rate_sel), .gain_sel(gain_sel),
    .sample_in(sample_in), .dm_bit(dm_bit), .bit_valid(bit_valid),
    .recon_out(recon_out), .overload(overload)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int clamp(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  // behavioural reference, advanced on each rising edge
  int m_cnt, m_acc, m_dacc, m_stp;
  bit m_tick, m_valid, m_bit, m_ovl;
  bit m_q[$];

  always @(posedge clk) begin
    int div, stp, o_stp, o_acc;
    bit o_tick, o_valid, o_bit, same;
    if (rst) begin
      m_cnt = 0; m_acc = 0; m_dacc = 0; m_stp = 0;
      m_tick = 0; m_valid = 0; m_bit = 0; m_ovl = 0;
      m_q.delete();
    end else begin
      div = BDIV >> rate_sel;
      stp = SBASE << gain_sel;
      o_tick = m_tick; o_valid = m_valid; o_bit = m_bit;
      o_stp = m_stp; o_acc = m_acc;
      m_tick = (m_cnt >= div - 1);
      m_cnt = m_tick ? 0 : m_cnt + 1;
      m_valid = o_tick;
      if (o_tick) begin
        m_bit = (int'(sample_in) > o_acc);
        m_acc = clamp(o_acc + (m_bit ? stp : -stp));
        m_stp = stp;
      end
      if (o_valid) begin
        m_dacc = clamp(m_dacc + (o_bit ? o_stp : -o_stp));
        m_q.push_back(o_bit);
        if (m_q.size() > 8) void'(m_q.pop_front());
        same = 1'b1;
        foreach (m_q[i]) if (m_q[i] != m_q[0]) same = 1'b0;
        m_ovl = (m_q.size() == 8) && same;
      end
    end
  end

  // cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      check("R7 strobe", int'(bit_valid), int'(m_valid));
      if (m_valid) check("R1 bit", int'(dm_bit), int'(m_bit));
      check("R8 recon (R2/R4/R5)", int'(recon_out), m_dacc);
      check("R9 overload", int'(overload), int'(m_ovl));
    end
  end

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_valid();
    do @(negedge clk); while (!bit_valid);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int r0, r1, t0, bits[$], mx;
    // R6: reset state
    repeat (4) @(negedge clk);
    check("R6 bit", int'(dm_bit), 0);
    check("R6 valid", int'(bit_valid), 0);
    check("R6 recon", int'(recon_out), 0);
    check("R6 overload", int'(overload), 0);
    rst = 1'b0;
    cmp_on = 1'b1;
    // R6: no strobe before the first tick (period 16 at rate 0)
    repeat (10) @(negedge clk);
    check("R6 no early strobe", int'(bit_valid), 0);

    // R10: zero input alternates starting with 0
    do_reset();
    sample_in = 0;
    for (int k = 0; k < 12; k++) begin wait_valid(); bits.push_back(int'(dm_bit)); end
    check("R10 first bit", bits[0], 0);
    for (int k = 1; k < 12; k++) check("R10 alternation", bits[k], 1 - bits[k-1]);

    // R3: tick spacing for each rate code
    for (int r = 0; r < 4; r++) begin
      rate_sel = 2'(r);
      wait_valid(); wait_valid();
      t0 = cycles;
      wait_valid();
      check("R3 tick period", cycles - t0, BDIV >> r);
    end

    // R4: step doubles with gain code
    for (int g = 0; g < 4; g++) begin
      gain_sel = 2'(g); rate_sel = 2'd3; sample_in = 16'sd30000;
      do_reset();
      wait_valid(); @(negedge clk); r0 = int'(recon_out);
      wait_valid(); @(negedge clk); r1 = int'(recon_out);
      check("R4 step size", r1 - r0, SBASE << g);
    end

    // R9: flag rises exactly on the 8th equal bit
    gain_sel = 2'd0; rate_sel = 2'd3; sample_in = 16'sd30000;
    do_reset();
    for (int k = 0; k < 7; k++) wait_valid();
    @(negedge clk);
    check("R9 flag low at 7 bits", int'(overload), 0);
    wait_valid(); @(negedge clk);
    check("R9 flag high at 8 bits", int'(overload), 1);

    // R5: clamp at both limits
    gain_sel = 2'd3; sample_in = 16'sd32767;
    do_reset();
    mx = 0;
    for (int k = 0; k < 80; k++) begin
      wait_valid(); @(negedge clk);
      if (int'(recon_out) > mx) mx = int'(recon_out);
    end
    check("R5 upper clamp", mx, 32767);
    sample_in = -16'sd32768;
    for (int k = 0; k < 150; k++) wait_valid();
    @(negedge clk);
    check("R5 lower clamp", int'(recon_out), -32768);

    // slope overload: fast triangle input with codes switching
    do_reset();
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      sample_in = 16'((k % 400 < 200) ? (k % 200) * 150 - 15000 : 15000 - (k % 200) * 150);
      if (k % 500 == 0) begin rate_sel = 2'(k / 500); gain_sel = 2'(k / 1000); end
    end

    cmp_on = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule